// File: doc/BRIEF.md
# Debug Data Breakpoint Matcher

This block watches every memory access a core makes and compares it against four programmable address breakpoints. Each access arrives with its start address, its size in bytes (1, 2 or 4) and a kind mask saying whether it is an instruction fetch, a data write or a data read. Each breakpoint slot has an enable bit, an address, a byte length (1, 2 or 4) and a kind mask that selects which access kinds it watches.

A slot hits when the byte range of the access and the byte range of the breakpoint share at least one byte. The test is done in both directions: the access may start at or below the breakpoint and reach into it, or it may start inside the breakpoint. Hits set bits in a four-bit sticky event vector. The bits stay set until a clear strobe with a mask removes them. A resume flag turns off all matching, for example while the faulting instruction is being restarted. Raising the debug exception and decoding the control registers are handled elsewhere.

Top module: `dbg_watch_matcher`

## Requirements
- R1: While `resume` is high, no access sets any bit of `hit_flags`.
- R2: A slot can set its bit only when its bit in `bp_en` is set. With `bp_en` all zero, no access sets any bit.
- R3: A slot can hit only when `bp_kind` of that slot ANDed with `acc_kind` is non-zero. The kind bits are: bit 0 instruction fetch, bit 1 data write, bit 2 data read.
- R4: A qualified slot hits when `acc_addr` <= its address and `acc_addr + acc_len` > its address.
- R5: A qualified slot hits when `acc_addr` > its address and `acc_addr` < its address plus its length.
- R6: A set bit of `hit_flags` stays set, whatever accesses follow, until it is cleared.
- R7: When `clr_valid` is high, the bits selected by `clr_mask` are 0 after the clock edge, even if a hit on the same slot occurs in that cycle. Bits that are not selected are not affected.
- R8: Accesses are evaluated only in cycles with `acc_valid` high. A hit is visible on `hit_flags` in the cycle after the edge that samples the access.
- R9: After reset, `hit_flags` is all zero.
- R10: Range ends are computed one bit wider than the address, so they do not wrap. An access at 0xFFFFFFFE of 4 bytes hits a breakpoint at 0xFFFFFFFF.

Slot i takes bits [i*32 +: 32] of `bp_addr` and bits [i*3 +: 3] of `bp_kind` and `bp_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access start address |
| acc_len | input | 3 | Access size in bytes (1, 2, 4) |
| acc_kind | input | 3 | Access kind mask (fetch, write, read) |
| resume | input | 1 | Suppresses all matching |
| bp_en | input | 4 | Per-slot enable |
| bp_addr | input | 128 | Breakpoint addresses, 32 bits per slot |
| bp_kind | input | 12 | Watched kinds, 3 bits per slot |
| bp_len | input | 12 | Breakpoint lengths in bytes, 3 bits per slot |
| clr_valid | input | 1 | Clear strobe |
| clr_mask | input | 4 | Event bits to clear |
| hit_flags | output | 4 | Sticky hit events |

## Verification
The event register is the only state. A wrong bit there shows on `hit_flags` in the cycle after the edge that wrote it, and it stays wrong until a clear, because the bits are sticky. A wrong bit therefore cannot hide. An error in the comparators shows only when an access lies close to a breakpoint edge. For that reason the random accesses are placed in a small window around the breakpoint addresses, and directed accesses cover each edge on both sides and the top of the address space.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  localparam int unsigned KIND_W    = 3;
  localparam int unsigned LEN_W     = 3;
  localparam int unsigned KIND_FETCH = 0;
  localparam int unsigned KIND_WRITE = 1;
  localparam int unsigned KIND_READ  = 2;
endpackage

// File: rtl/dbgw_slot_cmp.sv
module dbgw_slot_cmp
  import dbgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              slot_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [KIND_W-1:0] bp_kind,
  input  logic [LEN_W-1:0]  bp_len,
  output logic              slot_hit
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] acc_lo, acc_end, bp_lo, bp_end;
  logic kind_ok, low_side, high_side;

  // Range ends are one bit wider, so they do not wrap (R10)
  always_comb begin
    acc_lo  = {1'b0, acc_addr};
    bp_lo   = {1'b0, bp_addr};
    acc_end = acc_lo + EXT_W'(acc_len);
    bp_end  = bp_lo + EXT_W'(bp_len);
    kind_ok   = |(acc_kind & bp_kind);                     // R3
    low_side  = (acc_lo <= bp_lo) && (acc_end > bp_lo);    // R4
    high_side = (acc_lo > bp_lo) && (acc_lo < bp_end);     // R5
    slot_hit  = slot_en && kind_ok && (low_side || high_side);
  end

  // A hit always means the two byte ranges share a byte (R4, R5)
  always_comb begin
    if (slot_hit) begin
      assert_overlap_R4: assert ((acc_lo < bp_end) && (bp_lo < acc_end))
        else $error("slot hit without range overlap");
    end
  end
endmodule

// File: rtl/dbgw_event_reg.sv
module dbgw_event_reg #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [NUM_SLOTS-1:0] set_vec,
  input  logic                 clr_en,
  input  logic [NUM_SLOTS-1:0] clr_vec,
  output logic [NUM_SLOTS-1:0] flags
);
  logic [NUM_SLOTS-1:0] flags_q, flags_d, clr_eff, set_eff;
  logic                 upd;

  always_comb begin
    set_eff = set_en ? set_vec : '0;
    clr_eff = clr_en ? clr_vec : '0;
    upd     = set_en | clr_en;
    flags_d = (flags_q | set_eff) & ~clr_eff;   // clear wins (R7)
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R6: a bit that is not cleared never falls
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_q) & ~$past(clr_eff)) & ~flags_q) == '0));

  // R7: selected bits are zero after a clear
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff != '0) |=> ((flags_q & $past(clr_eff)) == '0));
endmodule

// File: rtl/dbg_watch_matcher.sv
module dbg_watch_matcher
  import dbgw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic [LEN_W-1:0]            acc_len,
  input  logic [KIND_W-1:0]           acc_kind,
  input  logic                        resume,
  input  logic [NUM_SLOTS-1:0]        bp_en,
  input  logic [NUM_SLOTS*ADDR_W-1:0] bp_addr,
  input  logic [NUM_SLOTS*KIND_W-1:0] bp_kind,
  input  logic [NUM_SLOTS*LEN_W-1:0]  bp_len,
  input  logic                        clr_valid,
  input  logic [NUM_SLOTS-1:0]        clr_mask,
  output logic [NUM_SLOTS-1:0]        hit_flags
);
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 match_gate;

  // R1, R2, R8: the whole matcher is gated
  assign match_gate = acc_valid && !resume && (|bp_en);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dbgw_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .slot_en  (bp_en[s]),
      .acc_addr (acc_addr),
      .acc_len  (acc_len),
      .acc_kind (acc_kind),
      .bp_addr  (bp_addr[s*ADDR_W +: ADDR_W]),
      .bp_kind  (bp_kind[s*KIND_W +: KIND_W]),
      .bp_len   (bp_len[s*LEN_W +: LEN_W]),
      .slot_hit (slot_hit[s])
    );
  end

  dbgw_event_reg #(.NUM_SLOTS(NUM_SLOTS)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (match_gate),
    .set_vec (slot_hit),
    .clr_en  (clr_valid),
    .clr_vec (clr_mask),
    .flags   (hit_flags)
  );

  // R1: nothing changes under resume without a clear
  assert_resume_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !clr_valid) |=> $stable(hit_flags));

  // R2: only enabled slots may raise their bit
  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_flags & ~$past(hit_flags) & ~$past(bp_en)) == '0));

  // R8: nothing changes without an access or a clear
  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !clr_valid) |=> $stable(hit_flags));
endmodule

// File: tb/dbg_watch_matcher_bench.sv
module dbg_watch_matcher_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         acc_valid, resume, clr_valid;
  logic [31:0]  acc_addr;
  logic [2:0]   acc_len, acc_kind;
  logic [3:0]   bp_en, clr_mask, hit_flags;
  logic [127:0] bp_addr;
  logic [11:0]  bp_kind, bp_len;
  logic [3:0]   exp_flags;
  int           errors = 0, checks = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  dbg_watch_matcher u_dbg_watch_matcher (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_len(acc_len), .acc_kind(acc_kind), .resume(resume), .bp_en(bp_en),
    .bp_addr(bp_addr), .bp_kind(bp_kind), .bp_len(bp_len),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .hit_flags(hit_flags)
  );

  function automatic logic [3:0] model_next(logic [3:0] cur);
    logic [3:0] hits = '0;
    longint a_lo, a_hi, b_lo, b_hi;
    if (acc_valid && !resume && bp_en != 0)
      for (int i = 0; i < 4; i++) begin
        a_lo = longint'(acc_addr);
        a_hi = a_lo + longint'(acc_len);
        b_lo = longint'(bp_addr[i*32 +: 32]);
        b_hi = b_lo + longint'(bp_len[i*3 +: 3]);
        if (bp_en[i] && (bp_kind[i*3 +: 3] & acc_kind) != 0 &&
            a_lo < b_hi && b_lo < a_hi) hits[i] = 1'b1;
      end
    cur = cur | hits;
    if (clr_valid) cur = cur & ~clr_mask;
    return cur;
  endfunction

  task automatic check(string req);
    checks++;
    if (hit_flags !== exp_flags) begin
      errors++;
      $display("FAIL %s: hit_flags=%b expected=%b", req, hit_flags, exp_flags);
    end
  endtask

  task automatic step(string req);
    exp_flags = model_next(exp_flags);
    @(posedge clk);
    @(negedge clk);
    check(req);
    acc_valid = 0; clr_valid = 0; resume = 0;
  endtask

  function automatic logic [2:0] pick_len();
    case ($urandom % 3) 0: return 3'd1; 1: return 3'd2; default: return 3'd4; endcase
  endfunction

  task automatic access(logic [31:0] a, logic [2:0] l, logic [2:0] k, string req);
    acc_valid = 1; acc_addr = a; acc_len = l; acc_kind = k;
    step(req);
  endtask

  task automatic clear_all();
    clr_valid = 1; clr_mask = 4'hF; step("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: hit_flags=%b expected=done", hit_flags);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; acc_valid = 0; resume = 0; clr_valid = 0; clr_mask = 0;
    acc_addr = 0; acc_len = 1; acc_kind = 0; bp_en = 0;
    bp_addr = {32'h130, 32'h120, 32'h110, 32'h100};
    bp_kind = {3'b111, 3'b100, 3'b010, 3'b001};
    bp_len  = {3'd4, 3'd2, 3'd1, 3'd4};
    exp_flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset");

    // r2_: nothing enabled
    access(32'h100, 3'd4, 3'b111, "R2 no enable");
    bp_en = 4'hF;
    // r1_: resume suppresses
    resume = 1; access(32'h100, 3'd4, 3'b111, "R1 resume");
    // r3_: kind mismatch on slot 0 (fetch only)
    access(32'h100, 3'd1, 3'b110, "R3 kind mismatch");
    access(32'h100, 3'd1, 3'b001, "R3 kind match");
    clear_all();
    // R4: access below reaching in; and just short
    access(32'h10F, 3'd1, 3'b010, "R4 miss below");
    access(32'h10E, 3'd4, 3'b010, "R4 reach in");
    clear_all();
    // R5: access starting inside / just past
    access(32'h122, 3'd1, 3'b100, "R5 just past end");
    access(32'h121, 3'd1, 3'b100, "R5 inside");
    // R6: stays set after misses
    access(32'h500, 3'd1, 3'b111, "R6 sticky");
    // R8: no strobe, nothing changes
    acc_addr = 32'h130; acc_kind = 3'b111; step("R8 no strobe");
    // R7: clear slot 3 while hitting it; slot 2 kept
    access(32'h130, 3'd1, 3'b111, "R8 hit");
    clr_valid = 1; clr_mask = 4'b1000;
    access(32'h131, 3'd1, 3'b111, "R7 clear priority");
    clear_all();
    // R10: top of address space
    bp_addr[31:0] = 32'hFFFF_FFFF;
    access(32'hFFFF_FFFE, 3'd4, 3'b001, "R10 no wrap");
    clear_all();
    bp_addr = {32'h130, 32'h120, 32'h110, 32'h100};

    for (int n = 0; n < 600; n++) begin
      if ($urandom % 16 == 0) begin
        bp_en = 4'($urandom);
        for (int i = 0; i < 4; i++) begin
          bp_addr[i*32 +: 32] = 32'h100 + ($urandom % 48);
          bp_kind[i*3 +: 3]   = 3'($urandom);
          bp_len[i*3 +: 3]    = pick_len();
        end
      end
      acc_valid = ($urandom % 4) != 0;
      acc_addr  = 32'h0FC + ($urandom % 56);
      acc_len   = pick_len();
      acc_kind  = 3'($urandom);
      resume    = ($urandom % 8) == 0;
      clr_valid = ($urandom % 6) == 0;
      clr_mask  = 4'($urandom);
      step("R4/R5 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule